// File: doc/BRIEF.md
# Prefetching Bus Interface Unit

This block sits between the execution unit of a small CPU and an 8-bit synchronous memory. Every memory access it makes is a four-state bus cycle (T1, T2, T3, T4). The state sequencer free-runs while the bus is idle, and a new transfer may start only in a T1 state. In each free T1 slot the unit serves a pending data read or write from the execution unit first. Otherwise it fetches the next opcode byte into a four-byte prefetch queue. The execution unit takes opcode bytes from that queue through a pop port, so only the queue decides what code it sees.

The wait-state setting stretches every transfer. Each wait state holds the bus in T4 for one more clock. An external hold input freezes the sequencer while a refresh or DMA cycle owns the bus. A stall counter loaded by the execution unit delays the start of new transfers without cutting short one already running. A flush empties the queue and moves the fetch pointer. A word request becomes two byte transfers, low address first. Opcode bytes already queued are not updated when memory is rewritten, so whether self-modifying code takes effect depends on fetch timing.

Top module: `biu_top`

## Requirements
- R1: A transfer spans four states and starts only in T1. The memory strobe `mem_en` is high for exactly one clock (T2) per transfer. With no wait states, back-to-back transfers strobe memory every 4 clocks.
- R2: With `wait_cfg` = w, each transfer holds T4 for w extra clocks, so back-to-back strobes are 4+w clocks apart.
- R3: When the bus is free and the queue (4 bytes) has room, the unit fetches consecutive bytes from the fetch pointer. Exactly 4 fetches fill an empty queue, and pops return the bytes in address order.
- R4: An execution-unit request pending at a T1 slot takes that slot ahead of a prefetch. With no wait states, a byte access completes (`eu_ready` seen) 5 to 8 clocks after the request clock, even while the queue is refilling.
- R5: A byte read returns `{8'h00, byte}` on `eu_rdata`. `eu_ready` is high for one clock only. `eu_rdata` changes only at T3 of a later read and stays stable while prefetches run.
- R6: A word access (`eu_word`=1) makes two byte transfers, low address first. Read data is `{byte[a+1], byte[a]}`. A write stores `eu_wdata[7:0]` at a and `eu_wdata[15:8]` at a+1. Completion comes once, after the second T4, 9 to 12 clocks after the request when there are no wait states.
- R7: A flush empties the queue and loads the fetch pointer from `flush_addr`. A prefetch not yet completed at that moment is discarded, so the next popped byte is the one at `flush_addr`.
- R8: A write to an address whose byte is already in the queue leaves the queued copy unchanged. A refill after a flush picks up the new value.
- R9: While `bus_hold` is high, `mem_en` stays low and the state sequencer does not advance.
- R10: Loading the stall counter with N blocks the start of any transfer for the N clocks after the load.
- R11: After reset the queue is empty, `eu_ready` and `mem_en` are low, and fetching starts at address `RESET_ADDR` (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eu_req | input | 1 | Request strobe from the execution unit, taken when no request is pending |
| eu_we | input | 1 | 1 = write, 0 = read |
| eu_word | input | 1 | 1 = 16-bit access split into two bytes |
| eu_addr | input | AW | Byte address of the access |
| eu_wdata | input | 16 | Write data, low byte first on the bus |
| eu_ready | output | 1 | One-clock completion pulse |
| eu_rdata | output | 16 | Read data, held between reads |
| q_pop | input | 1 | Remove the head byte of the queue |
| q_valid | output | 1 | Queue holds at least one byte |
| q_byte | output | 8 | Head byte of the queue |
| flush | input | 1 | Empty the queue and reload the fetch pointer |
| flush_addr | input | AW | New fetch pointer |
| stall_load | input | 1 | Load the stall counter |
| stall_cnt | input | STW | Number of clocks to block new transfers |
| bus_hold | input | 1 | Refresh or DMA owns the bus; freeze the sequencer |
| wait_cfg | input | WSW | Wait states added at T4 |
| mem_en | output | 1 | Memory strobe, one clock in T2 |
| mem_we | output | 1 | Write qualifier for `mem_en` |
| mem_addr | output | AW | Transfer address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, registered by the memory one clock after `mem_en` |

## Verification
A data request is accepted at the clock edge after it is driven. It then waits for the next T1, which is zero to three states away, and runs four states plus the wait states. Its `eu_ready` pulse therefore appears 5 to 8 clocks later for a byte, and four clocks more for a word. The bench checks these windows instead of a single cycle, because the sequencer phase at the moment of the request is free-running. Strobe spacing is measured between recorded `mem_en` clocks, so each wait setting must give exactly 4+w. The stall window is counted from the load edge: no strobe may appear at the 12 edges that follow a load of 12. Queue contents are compared only after a fill time longer than four worst-case transfers.

// File: rtl/biu_pkg.sv
package biu_pkg;
    typedef enum logic [1:0] {
        T1 = 2'd0,
        T2 = 2'd1,
        T3 = 2'd2,
        T4 = 2'd3
    } tstate_e;
endpackage

// File: rtl/biu_tseq.sv
module biu_tseq
    import biu_pkg::*;
#(
    parameter int WSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic           busy,
    input  logic [WSW-1:0] wait_cfg,
    output tstate_e        ph,
    output logic           adv
);
    typedef struct packed {
        tstate_e        ph;
        logic [WSW-1:0] ws;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [1:0] ph_nx;

    always_comb begin
        seq_d = seq_q;
        adv   = 1'b0;
        ph_nx = seq_q.ph + 2'd1;
        if (!hold) begin
            if (seq_q.ph == T4 && busy && seq_q.ws != wait_cfg) begin
                seq_d.ws = seq_q.ws + WSW'(1);
            end else begin
                adv      = 1'b1;
                seq_d.ph = tstate_e'(ph_nx);
                seq_d.ws = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{ph: T1, ws: '0};
        else        seq_q <= seq_d;
    end

    assign ph = seq_q.ph;
endmodule

// File: rtl/biu_pfq.sv
module biu_pfq #(
    parameter int DEPTH = 4,
    localparam int PW  = $clog2(DEPTH),
    localparam int QCW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           push,
    input  logic [7:0]     push_data,
    input  logic           pop,
    output logic           valid,
    output logic           room,
    output logic [7:0]     head,
    output logic [QCW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] slot;
        logic [PW-1:0]         rd;
        logic [PW-1:0]         wr;
        logic [QCW-1:0]        cnt;
    } pfq_t;

    pfq_t q_d, q_q;
    logic do_pop, do_push;

    always_comb begin
        q_d     = q_q;
        do_pop  = pop && (q_q.cnt != '0);
        do_push = push && ((q_q.cnt != QCW'(DEPTH)) || do_pop);
        if (clear) begin
            q_d.rd  = '0;
            q_d.wr  = '0;
            q_d.cnt = '0;
        end else begin
            if (do_push) begin
                q_d.slot[q_q.wr] = push_data;
                q_d.wr = (q_q.wr == PW'(DEPTH - 1)) ? '0 : q_q.wr + PW'(1);
            end
            if (do_pop) begin
                q_d.rd = (q_q.rd == PW'(DEPTH - 1)) ? '0 : q_q.rd + PW'(1);
            end
            if (do_push && !do_pop)      q_d.cnt = q_q.cnt + QCW'(1);
            else if (do_pop && !do_push) q_d.cnt = q_q.cnt - QCW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign valid = (q_q.cnt != '0);
    assign room  = (q_q.cnt != QCW'(DEPTH));
    assign head  = q_q.slot[q_q.rd];
    assign count = q_q.cnt;
endmodule

// File: rtl/biu_top.sv
module biu_top
    import biu_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          QDEPTH     = 4,
    parameter int          WSW        = 2,
    parameter int          STW        = 8,
    parameter logic [15:0] RESET_ADDR = 16'h0000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           eu_req,
    input  logic           eu_we,
    input  logic           eu_word,
    input  logic [AW-1:0]  eu_addr,
    input  logic [15:0]    eu_wdata,
    output logic           eu_ready,
    output logic [15:0]    eu_rdata,
    input  logic           q_pop,
    output logic           q_valid,
    output logic [7:0]     q_byte,
    input  logic           flush,
    input  logic [AW-1:0]  flush_addr,
    input  logic           stall_load,
    input  logic [STW-1:0] stall_cnt,
    input  logic           bus_hold,
    input  logic [WSW-1:0] wait_cfg,
    output logic           mem_en,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [7:0]     mem_wdata,
    input  logic [7:0]     mem_rdata
);
    localparam int QCW = $clog2(QDEPTH + 1);
    localparam logic [QCW-1:0] QFULL = QCW'(QDEPTH);

    typedef struct packed {
        logic           busy;
        logic           to_eu;
        logic [AW-1:0]  xaddr;
        logic           xwe;
        logic [7:0]     xdat;
        logic           pend;
        logic           we;
        logic           word;
        logic           hi;
        logic [AW-1:0]  addr;
        logic [15:0]    wdata;
        logic [15:0]    rdata;
        logic           ready;
        logic [AW-1:0]  fptr;
        logic           cancel;
        logic [7:0]     pfb;
        logic [STW-1:0] stall;
    } st_t;

    st_t st_d, st_q;
    tstate_e ph;
    logic adv, push, q_room;
    logic [QCW-1:0] q_cnt;

    biu_tseq #(.WSW(WSW)) u_tseq (
        .clk(clk), .rst_n(rst_n), .hold(bus_hold), .busy(st_q.busy),
        .wait_cfg(wait_cfg), .ph(ph), .adv(adv)
    );

    biu_pfq #(.DEPTH(QDEPTH)) u_pfq (
        .clk(clk), .rst_n(rst_n), .clear(flush), .push(push),
        .push_data(st_q.pfb), .pop(q_pop), .valid(q_valid), .room(q_room),
        .head(q_byte), .count(q_cnt)
    );

    always_comb begin
        st_d       = st_q;
        push       = 1'b0;
        st_d.ready = 1'b0;
        if (stall_load)            st_d.stall = stall_cnt;
        else if (st_q.stall != '0) st_d.stall = st_q.stall - STW'(1);
        if (eu_req && !st_q.pend) begin
            st_d.pend  = 1'b1;
            st_d.we    = eu_we;
            st_d.word  = eu_word;
            st_d.hi    = 1'b0;
            st_d.addr  = eu_addr;
            st_d.wdata = eu_wdata;
        end
        if (adv) begin
            case (ph)
                T1: if (!st_q.busy && st_q.stall == '0) begin
                    if (st_q.pend) begin
                        st_d.busy  = 1'b1;
                        st_d.to_eu = 1'b1;
                        st_d.xaddr = st_q.addr + AW'(st_q.hi);
                        st_d.xwe   = st_q.we;
                        st_d.xdat  = st_q.hi ? st_q.wdata[15:8] : st_q.wdata[7:0];
                    end else if (q_room && !flush) begin
                        st_d.busy   = 1'b1;
                        st_d.to_eu  = 1'b0;
                        st_d.xaddr  = st_q.fptr;
                        st_d.xwe    = 1'b0;
                        st_d.cancel = 1'b0;
                    end
                end
                T3: if (st_q.busy && !st_q.xwe) begin
                    if (!st_q.to_eu)  st_d.pfb = mem_rdata;
                    else if (st_q.hi) st_d.rdata[15:8] = mem_rdata;
                    else              st_d.rdata = {8'h00, mem_rdata};
                end
                T4: if (st_q.busy) begin
                    st_d.busy = 1'b0;
                    if (st_q.to_eu) begin
                        if (st_q.word && !st_q.hi) begin
                            st_d.hi = 1'b1;
                        end else begin
                            st_d.pend  = 1'b0;
                            st_d.ready = 1'b1;
                        end
                    end else if (!st_q.cancel && !flush) begin
                        push      = 1'b1;
                        st_d.fptr = st_q.fptr + AW'(1);
                    end
                end
                default: ;
            endcase
        end
        if (flush) begin
            st_d.fptr = flush_addr;
            if (st_q.busy && !st_q.to_eu) st_d.cancel = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.fptr <= AW'(RESET_ADDR);
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_en    = st_q.busy && (ph == T2) && !bus_hold;
    assign mem_we    = mem_en && st_q.xwe;
    assign mem_addr  = st_q.xaddr;
    assign mem_wdata = st_q.xdat;
    assign eu_ready  = st_q.ready;
    assign eu_rdata  = st_q.rdata;
endmodule

// File: rtl/biu_chk.sv
module biu_chk
    import biu_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    bus_hold,
    input logic    mem_en,
    input logic    eu_ready,
    input logic    q_ok,
    input tstate_e ph,
    input logic    busy,
    input logic    stall_nz
);
    // R9
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |-> !mem_en);

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |=> $stable(ph));

    // R1
    strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !mem_en);

    // R5
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eu_ready |=> !eu_ready);

    // R3
    q_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_ok);

    // R10
    stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_nz && ph == T1 && !busy) |=> !busy);
endmodule

bind biu_top biu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_hold(bus_hold), .mem_en(mem_en),
    .eu_ready(eu_ready), .q_ok(q_cnt <= QFULL), .ph(ph),
    .busy(st_q.busy), .stall_nz(st_q.stall != '0)
);

// File: tb/tb_biu_top.sv
`timescale 1ns/1ps
module tb_biu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eu_req = 0, eu_we = 0, eu_word = 0;
    logic [15:0] eu_addr = 0, eu_wdata = 0;
    logic        eu_ready;
    logic [15:0] eu_rdata;
    logic        q_pop = 0, q_valid;
    logic [7:0]  q_byte;
    logic        flush = 0;
    logic [15:0] flush_addr = 0;
    logic        stall_load = 0;
    logic [7:0]  stall_cnt = 0;
    logic        bus_hold = 0;
    logic [1:0]  wait_cfg = 0;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 0;
    logic [7:0]  tmem [256];

    int nchk = 0, nfail = 0, cyc = 0, en_n = 0;
    int en_t [8];

    always #4 clk = ~clk;

    biu_top dut (
        .clk(clk), .rst_n(rst_n), .eu_req(eu_req), .eu_we(eu_we), .eu_word(eu_word),
        .eu_addr(eu_addr), .eu_wdata(eu_wdata), .eu_ready(eu_ready), .eu_rdata(eu_rdata),
        .q_pop(q_pop), .q_valid(q_valid), .q_byte(q_byte), .flush(flush),
        .flush_addr(flush_addr), .stall_load(stall_load), .stall_cnt(stall_cnt),
        .bus_hold(bus_hold), .wait_cfg(wait_cfg), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) tmem[i] <= pat(i);
        end else if (mem_en) begin
            if (mem_we) tmem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= tmem[mem_addr[7:0]];
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mem_en) begin
            en_t[en_n % 8] = cyc;
            en_n = en_n + 1;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(string req, string what, int act, int lo, int hi);
        nchk++;
        if (act < lo || act > hi) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_flush(int a);
        flush = 1; flush_addr = 16'(a);
        @(negedge clk);
        flush = 0;
    endtask

    task automatic pop_chk(string req, int exp);
        chk(req, "queue valid", int'(q_valid), 1);
        chk(req, "queued byte", int'(q_byte), exp);
        q_pop = 1;
        @(negedge clk);
        q_pop = 0;
    endtask

    task automatic eu_op(bit we, bit word, int a, int wd, output int lat);
        eu_req = 1; eu_we = we; eu_word = word; eu_addr = 16'(a); eu_wdata = 16'(wd);
        @(negedge clk);
        eu_req = 0;
        lat = 1;
        while (!eu_ready && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        chk("R5", "ready lasts one clock", int'(eu_ready), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int lat, n0, hold_rd;
        tick(3);
        rst_n = 1;
        // R11 reset state
        chk("R11", "q_valid after reset", int'(q_valid), 0);
        chk("R11", "eu_ready after reset", int'(eu_ready), 0);
        chk("R11", "mem_en after reset", int'(mem_en), 0);
        tick(40);
        for (int i = 0; i < 4; i++) pop_chk("R11", pat(i));
        tick(40);

        // R1 / R2 / R3 / R7: strobe spacing per wait setting, fill from flush address
        for (int w = 0; w < 4; w++) begin
            wait_cfg = 2'(w);
            tick(40);
            n0 = en_n;
            do_flush(16'h40 + 16 * w);
            tick(45);
            chk("R3", "fetches to fill queue", en_n - n0, 4);
            for (int k = 0; k < 3; k++)
                chk(w == 0 ? "R1" : "R2", "strobe spacing",
                    en_t[(n0 + k + 1) % 8] - en_t[(n0 + k) % 8], 4 + w);
            for (int i = 0; i < 4; i++) pop_chk("R7", pat(16'h40 + 16 * w + i));
        end
        wait_cfg = 0;
        tick(40);

        // R4: request beats refill of an empty queue
        do_flush(16'h80);
        eu_op(0, 0, 16'h10, 0, lat);
        chk_rng("R4", "byte read latency", lat, 5, 8);
        chk("R5", "byte read data", int'(eu_rdata), {8'h00, pat(16'h10)});
        tick(40);

        // R6: word read
        n0 = en_n;
        eu_op(0, 1, 16'h22, 0, lat);
        chk_rng("R6", "word read latency", lat, 9, 12);
        chk("R6", "strobes for word", en_n - n0, 2);
        chk("R6", "word read data", int'(eu_rdata), {pat(16'h23), pat(16'h22)});

        // R5: data held while prefetches run
        hold_rd = int'(eu_rdata);
        pop_chk("R7", pat(16'h80));
        tick(10);
        chk("R5", "read data held", int'(eu_rdata), hold_rd);

        // R6: word write
        eu_op(1, 1, 16'h20, 16'hBEEF, lat);
        chk_rng("R6", "word write latency", lat, 9, 12);
        chk("R6", "low byte stored", int'(tmem[8'h20]), 16'hEF);
        chk("R6", "high byte stored", int'(tmem[8'h21]), 16'hBE);
        eu_op(0, 0, 16'h21, 0, lat);
        chk("R6", "byte readback", int'(eu_rdata), 16'h00BE);

        // R8: queued copy survives a write
        do_flush(16'h30);
        tick(40);
        eu_op(1, 0, 16'h31, 16'h005A, lat);
        chk("R8", "memory written", int'(tmem[8'h31]), 16'h5A);
        for (int i = 0; i < 4; i++) pop_chk("R8", pat(16'h30 + i));
        do_flush(16'h30);
        tick(40);
        pop_chk("R8", pat(16'h30));
        pop_chk("R8", 16'h5A);
        tick(40);

        // R9: hold blocks all transfers
        bus_hold = 1;
        do_flush(16'h50);
        n0 = en_n;
        tick(20);
        chk("R9", "strobes during hold", en_n - n0, 0);
        chk("R9", "queue empty during hold", int'(q_valid), 0);
        bus_hold = 0;
        tick(40);
        for (int i = 0; i < 4; i++) pop_chk("R9", pat(16'h50 + i));
        tick(40);

        // R10: stall window of 12 clocks
        flush = 1; flush_addr = 16'h60; stall_load = 1; stall_cnt = 8'd12;
        @(negedge clk);
        flush = 0; stall_load = 0;
        n0 = en_n;
        tick(12);
        chk("R10", "strobes in stall window", en_n - n0, 0);
        tick(10);
        chk_rng("R10", "fetch resumes after stall", en_n - n0, 1, 8);
        tick(40);
        for (int i = 0; i < 4; i++) pop_chk("R10", pat(16'h60 + i));

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule